// File: doc/BRIEF.md
# Packet-Disk Channel Register Block

This block holds the software-visible control and status registers for a set of packet-DMA disk channels. It sits on a simple word-wide memory-mapped bus with byte enables. For each channel it stores a control word, a sticky status byte, a command-packet count, a next-packet pointer, a lookup word and a pair of FIFO thresholds. It drives a single-cycle start pulse, a synchronous engine-reset level and a masked interrupt toward each channel's packet engine.

The engine reports events as one-cycle pulses. The block accumulates them into status bits that stay set until software reads the status byte; that read returns the collected value and empties it. A start request written to the control word only launches the engine when two conditions hold. The global lock byte must hold the unlock code. The channel's engine must be idle, meaning no packet is in flight since the last start. A channel whose engine-reset bit is set holds its engine idle and its status empty, and keeps its pointer, count and threshold settings.

Each channel's register window sits at 0x80 plus 0x20 times the channel number. The lock byte is global and sits at byte address 0xC7.

Top module: `pktchan_csr`

## Requirements
- R1: After reset every channel's control word reads 0x0100 (interrupt mask set, all else clear). The status, count, pointer, lookup and threshold registers and the lock byte read zero. startPulse, engReset and irq are low.
- R2: Channel n's window starts at 0x80 + 0x20·n. Word offsets within the window are: control in bits 15:0 and status in bits 23:16 at 0x00, count at 0x04 (bits 15:0), next pointer at 0x0C, lookup at 0x10, and thresholds at 0x14 (input in 15:0, output in 31:16). Writes update only the byte lanes whose busBe bit is set. Words 0x08, 0x18 and 0x1C read zero and ignore writes. pioMode follows control bits 1:0.
- R3: Read data appears on busRdData in the cycle after the read is presented and holds until the next read.
- R4: The engine's event bits 6 (packet done), 4 (unexpected interrupt) and 0 (bus error) set sticky status bits. All other event bits are ignored. Bus writes to the status byte have no effect.
- R5: A read of control word 0x00 with busBe[2] set returns the status byte as it was, then clears it. An event arriving in the same cycle as that read stays set. A read without busBe[2] leaves status untouched.
- R6: Writing control bit 7 with busBe[0], when the request is accepted, produces startPulse high for exactly the one cycle after the write. Bit 7 is not stored and reads back 0.
- R7: A start request is ignored unless the lock byte holds 7 and the engine is idle. It is also ignored when the same write sets bit 5. The engine counts as busy from an accepted start until a packet-done event (bit 6) or an engine reset.
- R8: While control bit 5 is set, engReset is high. Status is held clear and events are ignored. The engine is forced idle. Count, pointer, lookup and threshold values are kept.
- R9: irq for a channel is high exactly when any of its sticky status bits is set and its control bit 8 (mask) is clear.
- R10: The lock byte at address 0xC7 (word 0xC4, byte lane 3) is read/write. Only the value 7 enables start requests.
- R11: Accesses and events for one channel leave every other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address (bits 1:0 ignored) |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busBe | input | 4 | Byte-lane enables |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| engEvt | input | NUM_CH·8 | Per-channel engine event pulses |
| startPulse | output | NUM_CH | One-cycle engine start |
| engReset | output | NUM_CH | Engine reset level |
| irq | output | NUM_CH | Masked interrupt |
| pioMode | output | NUM_CH·2 | Programmed-I/O mode field |
| pktCount | output | NUM_CH·16 | Command-packet count |
| nextPtr | output | NUM_CH·32 | Next-packet address |
| lookupWord | output | NUM_CH·32 | Lookup register |
| inThr | output | NUM_CH·16 | Input FIFO threshold |
| outThr | output | NUM_CH·16 | Output FIFO threshold |

## Verification
A wrong busy flag shows up at startPulse on the very next start request. It either drops a legitimate launch or emits a second pulse while a packet is in flight. A corrupted sticky byte shows on irq in the same cycle and on the next status read one cycle after it is issued. A missed clear-on-read or a lost coincident event is caught by the read that follows. Lane-merge or decode faults show on the register's output port one cycle after the write, and on the other channel's ports as unexpected changes.

// File: rtl/pktchan_csr_pkg.sv
package pktchan_csr_pkg;

  localparam int BUS_W  = 32;
  localparam int BE_W   = BUS_W / 8;
  localparam int ADDR_W = 8;
  localparam int WIDX_W = 3;               // word index inside a channel window
  localparam int CNT_W  = 16;
  localparam int PTR_W  = 32;
  localparam int THR_W  = 16;
  localparam int MODE_W = 2;
  localparam int ST_W   = 8;

  // control word bit positions
  localparam int CB_RST  = 5;
  localparam int CB_GO   = 7;
  localparam int CB_MASK = 8;

  // status bit positions
  localparam int SB_PERR  = 0;
  localparam int SB_UNEXP = 4;
  localparam int SB_DONE  = 6;
  localparam logic [ST_W-1:0] ST_KEEP =
    ST_W'((1 << SB_DONE) | (1 << SB_UNEXP) | (1 << SB_PERR));

  // status byte lane inside word 0
  localparam int ST_LANE = 2;

  // word indices inside a channel window
  localparam logic [WIDX_W-1:0] W_CTRL   = 3'd0;
  localparam logic [WIDX_W-1:0] W_COUNT  = 3'd1;
  localparam logic [WIDX_W-1:0] W_NEXT   = 3'd3;
  localparam logic [WIDX_W-1:0] W_LOOKUP = 3'd4;
  localparam logic [WIDX_W-1:0] W_THR    = 3'd5;

  localparam logic [7:0] LOCK_OPEN = 8'd7;

  typedef struct packed {
    logic wrCtrl;
    logic wrCount;
    logic wrNext;
    logic wrLookup;
    logic wrThr;
    logic rdStat;
    logic goReq;
  } chanStb_t;

  function automatic logic [BUS_W-1:0] laneMerge(input logic [BUS_W-1:0] oldW,
                                                 input logic [BUS_W-1:0] newW,
                                                 input logic [BE_W-1:0]  be);
    logic [BUS_W-1:0] res;
    res = oldW;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) res[b*8 +: 8] = newW[b*8 +: 8];
    return res;
  endfunction

endpackage

// File: rtl/pktchan_csr_ctrl.sv
module pktchan_csr_ctrl
  import pktchan_csr_pkg::*;
#(
  parameter int                NUM_CH    = 2,
  parameter logic [ADDR_W-1:0] CH_BASE   = 8'h80,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hC7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrEn,
  input  logic                    busRdEn,
  input  logic [BE_W-1:0]         busBe,
  input  logic [BUS_W-1:0]        busWrData,
  input  logic [NUM_CH*BUS_W-1:0] chanRdWord,
  output chanStb_t                stb [NUM_CH],
  output logic [WIDX_W-1:0]       wordIdx,
  output logic                    lockOpen,
  output logic [BUS_W-1:0]        busRdData
);

  localparam int STRIDE_B  = WIDX_W + 2;
  localparam int STRIDE    = 1 << STRIDE_B;
  localparam int LOCK_LANE = int'(LOCK_ADDR[1:0]);

  logic [7:0]        lockQ;
  logic [NUM_CH-1:0] chanHit;
  logic              lockHit;
  logic [BUS_W-1:0]  rdNext;

  assign wordIdx  = busAddr[STRIDE_B-1:2];
  assign lockHit  = (busAddr[ADDR_W-1:2] == LOCK_ADDR[ADDR_W-1:2]);
  assign lockOpen = (lockQ == LOCK_OPEN);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(int'(CH_BASE) + i * STRIDE);
    assign chanHit[i] = (busAddr[ADDR_W-1:STRIDE_B] == WIN[ADDR_W-1:STRIDE_B]);

    logic wrHit, rdHit;
    assign wrHit = busWrEn & chanHit[i];
    assign rdHit = busRdEn & chanHit[i];

    assign stb[i].wrCtrl   = wrHit & (wordIdx == W_CTRL);
    assign stb[i].wrCount  = wrHit & (wordIdx == W_COUNT);
    assign stb[i].wrNext   = wrHit & (wordIdx == W_NEXT);
    assign stb[i].wrLookup = wrHit & (wordIdx == W_LOOKUP);
    assign stb[i].wrThr    = wrHit & (wordIdx == W_THR);
    assign stb[i].rdStat   = rdHit & (wordIdx == W_CTRL) & busBe[ST_LANE];
    // start request: lane 0 carries go, and the same write must not assert reset
    assign stb[i].goReq    = wrHit & (wordIdx == W_CTRL) & busBe[0] &
                             busWrData[CB_GO] & ~busWrData[CB_RST] & lockOpen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      lockQ <= '0;
    else if (busWrEn && lockHit && busBe[LOCK_LANE])
      lockQ <= busWrData[LOCK_LANE*8 +: 8];
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (chanHit[i]) rdNext = chanRdWord[i*BUS_W +: BUS_W];
    if (lockHit) rdNext[LOCK_LANE*8 +: 8] = lockQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      busRdData <= '0;
    else if (busRdEn)
      busRdData <= rdNext;
  end

endmodule

// File: rtl/pktchan_csr_chan.sv
module pktchan_csr_chan
  import pktchan_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chanStb_t          stb,
  input  logic [BE_W-1:0]   be,
  input  logic [BUS_W-1:0]  wd,
  input  logic [WIDX_W-1:0] wordIdx,
  input  logic [ST_W-1:0]   evt,
  output logic [BUS_W-1:0]  rdWord,
  output logic              startPulse,
  output logic              engReset,
  output logic              irq,
  output logic              engBusy,
  output logic [MODE_W-1:0] pioMode,
  output logic [CNT_W-1:0]  pktCount,
  output logic [PTR_W-1:0]  nextPtr,
  output logic [PTR_W-1:0]  lookupWord,
  output logic [THR_W-1:0]  inThr,
  output logic [THR_W-1:0]  outThr,
  output logic [ST_W-1:0]   sticky
);

  logic              maskQ, rstQ, busyQ, goQ;
  logic [MODE_W-1:0] modeQ;
  logic [CNT_W-1:0]  countQ;
  logic [PTR_W-1:0]  nextQ, lookQ;
  logic [THR_W-1:0]  inThrQ, outThrQ;
  logic [ST_W-1:0]   stickyQ;

  logic [BUS_W-1:0]  cntMerged, nextMerged, lookMerged, thrMerged;
  logic              rstNext, goAccept;
  logic [15:0]       ctrlRd;

  always_comb begin
    cntMerged  = laneMerge(BUS_W'(countQ), wd, be);
    nextMerged = laneMerge(BUS_W'(nextQ), wd, be);
    lookMerged = laneMerge(BUS_W'(lookQ), wd, be);
    thrMerged  = laneMerge(BUS_W'({outThrQ, inThrQ}), wd, be);
  end

  // reset level as it will be after this edge; status and busy follow it at once
  assign rstNext  = (stb.wrCtrl && be[0]) ? wd[CB_RST] : rstQ;
  assign goAccept = stb.goReq & ~busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= 1'b1;
      rstQ    <= 1'b0;
      modeQ   <= '0;
      countQ  <= '0;
      nextQ   <= '0;
      lookQ   <= '0;
      inThrQ  <= '0;
      outThrQ <= '0;
      stickyQ <= '0;
      busyQ   <= 1'b0;
      goQ     <= 1'b0;
    end else begin
      if (stb.wrCtrl && be[0]) begin
        rstQ  <= wd[CB_RST];
        modeQ <= wd[MODE_W-1:0];
      end
      if (stb.wrCtrl && be[1]) maskQ <= wd[CB_MASK];
      if (stb.wrCount)  countQ <= cntMerged[CNT_W-1:0];
      if (stb.wrNext)   nextQ  <= nextMerged[PTR_W-1:0];
      if (stb.wrLookup) lookQ  <= lookMerged[PTR_W-1:0];
      if (stb.wrThr) begin
        inThrQ  <= thrMerged[THR_W-1:0];
        outThrQ <= thrMerged[2*THR_W-1:THR_W];
      end

      goQ <= goAccept;

      if (rstNext)           busyQ <= 1'b0;
      else if (goAccept)     busyQ <= 1'b1;
      else if (evt[SB_DONE]) busyQ <= 1'b0;

      if (rstNext) stickyQ <= '0;
      else         stickyQ <= (stb.rdStat ? '0 : stickyQ) | (evt & ST_KEEP);
    end
  end

  always_comb begin
    ctrlRd = '0;
    ctrlRd[MODE_W-1:0] = modeQ;
    ctrlRd[CB_RST]     = rstQ;
    ctrlRd[CB_MASK]    = maskQ;
  end

  always_comb begin
    rdWord = '0;
    case (wordIdx)
      W_CTRL:   begin
                  rdWord[15:0] = ctrlRd;
                  rdWord[ST_LANE*8 +: ST_W] = stickyQ;
                end
      W_COUNT:  rdWord[CNT_W-1:0] = countQ;
      W_NEXT:   rdWord[PTR_W-1:0] = nextQ;
      W_LOOKUP: rdWord[PTR_W-1:0] = lookQ;
      W_THR:    rdWord[2*THR_W-1:0] = {outThrQ, inThrQ};
      default:  rdWord = '0;
    endcase
  end

  assign startPulse = goQ;
  assign engReset   = rstQ;
  assign engBusy    = busyQ;
  assign irq        = (|stickyQ) & ~maskQ;
  assign pioMode    = modeQ;
  assign pktCount   = countQ;
  assign nextPtr    = nextQ;
  assign lookupWord = lookQ;
  assign inThr      = inThrQ;
  assign outThr     = outThrQ;
  assign sticky     = stickyQ;

endmodule

// File: rtl/pktchan_csr.sv
module pktchan_csr
  import pktchan_csr_pkg::*;
#(
  parameter int                NUM_CH    = 2,
  parameter logic [ADDR_W-1:0] CH_BASE   = 8'h80,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hC7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic                     busRdEn,
  input  logic [BE_W-1:0]          busBe,
  input  logic [BUS_W-1:0]         busWrData,
  output logic [BUS_W-1:0]         busRdData,
  input  logic [NUM_CH*ST_W-1:0]   engEvt,
  output logic [NUM_CH-1:0]        startPulse,
  output logic [NUM_CH-1:0]        engReset,
  output logic [NUM_CH-1:0]        irq,
  output logic [NUM_CH*MODE_W-1:0] pioMode,
  output logic [NUM_CH*CNT_W-1:0]  pktCount,
  output logic [NUM_CH*PTR_W-1:0]  nextPtr,
  output logic [NUM_CH*PTR_W-1:0]  lookupWord,
  output logic [NUM_CH*THR_W-1:0]  inThr,
  output logic [NUM_CH*THR_W-1:0]  outThr
);

  chanStb_t                stb [NUM_CH];
  logic [WIDX_W-1:0]       wordIdx;
  logic                    lockOpen;
  logic [NUM_CH*BUS_W-1:0] chanRdWord;
  logic [NUM_CH*ST_W-1:0]  stickyFlat;
  logic [NUM_CH-1:0]       busyFlat;

  pktchan_csr_ctrl #(
    .NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .LOCK_ADDR(LOCK_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busBe(busBe), .busWrData(busWrData),
    .chanRdWord(chanRdWord), .stb(stb), .wordIdx(wordIdx),
    .lockOpen(lockOpen), .busRdData(busRdData)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    pktchan_csr_chan u_chan (
      .clk(clk), .rstN(rstN), .stb(stb[i]), .be(busBe), .wd(busWrData),
      .wordIdx(wordIdx), .evt(engEvt[i*ST_W +: ST_W]),
      .rdWord(chanRdWord[i*BUS_W +: BUS_W]),
      .startPulse(startPulse[i]), .engReset(engReset[i]), .irq(irq[i]),
      .engBusy(busyFlat[i]), .pioMode(pioMode[i*MODE_W +: MODE_W]),
      .pktCount(pktCount[i*CNT_W +: CNT_W]), .nextPtr(nextPtr[i*PTR_W +: PTR_W]),
      .lookupWord(lookupWord[i*PTR_W +: PTR_W]),
      .inThr(inThr[i*THR_W +: THR_W]), .outThr(outThr[i*THR_W +: THR_W]),
      .sticky(stickyFlat[i*ST_W +: ST_W])
    );
  end

endmodule

// File: rtl/pktchan_csr_chk.sv
module pktchan_csr_chk
  import pktchan_csr_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_CH-1:0]      startPulse,
  input logic [NUM_CH-1:0]      engReset,
  input logic [NUM_CH-1:0]      irq,
  input logic                   lockOpen,
  input logic [NUM_CH*ST_W-1:0] stickyFlat,
  input logic [NUM_CH-1:0]      busyFlat
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
    // R6: an accepted start leaves the engine busy, so the pulse lasts one cycle
    a_r6_start_marks_busy: assert property (@(posedge clk) disable iff (!rstN)
      startPulse[i] |-> busyFlat[i]);
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
      startPulse[i] |=> !startPulse[i]);
    // R7: a launch needs the lock open and an idle engine in the request cycle
    a_r7_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
      startPulse[i] |-> $past(lockOpen));
    a_r7_needs_idle: assert property (@(posedge clk) disable iff (!rstN)
      startPulse[i] |-> !$past(busyFlat[i]));
    // R8: engine reset holds status empty, interrupt low, engine idle
    a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
      engReset[i] |-> (stickyFlat[i*ST_W +: ST_W] == '0) && !irq[i] && !busyFlat[i]);
    // R9: no interrupt without a pending status bit
    a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rstN)
      irq[i] |-> (|stickyFlat[i*ST_W +: ST_W]));
  end

endmodule

bind pktchan_csr pktchan_csr_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .engReset(engReset),
  .irq(irq), .lockOpen(lockOpen), .stickyFlat(stickyFlat), .busyFlat(busyFlat)
);

// File: tb/pktchan_csr_bench.sv
`timescale 1ns/1ps
module pktchan_csr_bench;

  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [15:0] engEvt = '0;
  logic [1:0]  startPulse, engReset, irq;
  logic [3:0]  pioMode;
  logic [31:0] pktCount, inThr, outThr;
  logic [63:0] nextPtr, lookupWord;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  pktchan_csr u_pktchan_csr (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busBe(busBe), .busWrData(busWrData),
    .busRdData(busRdData), .engEvt(engEvt), .startPulse(startPulse),
    .engReset(engReset), .irq(irq), .pioMode(pioMode), .pktCount(pktCount),
    .nextPtr(nextPtr), .lookupWord(lookupWord), .inThr(inThr), .outThr(outThr)
  );

  // bench model of the data registers
  logic [15:0] mCount [NCH];
  logic [31:0] mNext  [NCH];
  logic [31:0] mLook  [NCH];
  logic [15:0] mIn    [NCH];
  logic [15:0] mOut   [NCH];
  logic [7:0]  mSt    [NCH];
  logic [15:0] mCtrl  [NCH];

  function automatic logic [7:0] regAddr(input int ch, input int word);
    return 8'(8'h80 + ch * 32 + word * 4);
  endfunction

  function automatic logic [31:0] byteMix(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
    logic [31:0] r;
    r = o;
    for (int k = 0; k < 4; k++) if (be[k]) r[k*8 +: 8] = n[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] modelWord(input int ch, input int word);
    case (word)
      0: return {8'h00, mSt[ch], mCtrl[ch]};
      1: return {16'h0, mCount[ch]};
      3: return mNext[ch];
      4: return mLook[ch];
      5: return {mOut[ch], mIn[ch]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busAddr = a; busWrData = d; busBe = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busBe = '0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busBe = be; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0; busBe = '0;
    d = busRdData;
  endtask

  task automatic evtPulse(input int ch, input logic [7:0] e);
    @(negedge clk);
    engEvt[ch*8 +: 8] = e;
    @(negedge clk);
    engEvt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 startPulse", 32'(startPulse), 32'h0);
    chk("R1 engReset", 32'(engReset), 32'h0);
    busRead(8'h80, 4'hF, rd); chk("R1 ctrl ch0", rd, 32'h0000_0100);
    busRead(8'hA0, 4'hF, rd); chk("R1 ctrl ch1", rd, 32'h0000_0100);
    busRead(8'hC4, 4'hF, rd); chk("R1 lock", rd, 32'h0);
    busRead(8'h84, 4'hF, rd); chk("R1 count", rd, 32'h0);

    // R7 start with lock closed
    busWrite(8'h80, 32'h0000_0083, 4'h3);
    chk("R7 go while locked", 32'(startPulse), 32'h0);

    // R10 lock byte
    busWrite(8'hC4, 32'h0500_0000, 4'h8);
    busRead(8'hC4, 4'hF, rd); chk("R10 lock readback", rd, 32'h0500_0000);
    busWrite(8'h80, 32'h0000_0083, 4'h1);
    chk("R10 wrong lock value", 32'(startPulse), 32'h0);
    busWrite(8'hC4, 32'h0700_0000, 4'h8);
    busRead(8'hC4, 4'hF, rd); chk("R10 lock open", rd, 32'h0700_0000);

    // R6 start pulse
    busWrite(8'h80, 32'h0000_0083, 4'h1);
    chk("R6 pulse high", 32'(startPulse), 32'h1);
    @(negedge clk);
    chk("R6 pulse one cycle", 32'(startPulse), 32'h0);
    busRead(8'h80, 4'h3, rd); chk("R6 go reads zero", rd, 32'h0000_0003);

    // R7 busy, then done frees the engine
    busWrite(8'h80, 32'h0000_0083, 4'h1);
    chk("R7 go while busy", 32'(startPulse), 32'h0);
    evtPulse(0, 8'h40);
    chk("R9 irq after done", 32'(irq), 32'h1);
    busWrite(8'h80, 32'h0000_0083, 4'h1);
    chk("R6 go after done", 32'(startPulse), 32'h1);

    // R5 clear on read
    busRead(8'h80, 4'h4, rd); chk("R5 status read", rd, 32'h0040_0003);
    @(negedge clk);
    chk("R3 read data holds", busRdData, 32'h0040_0003);
    busRead(8'h80, 4'h4, rd); chk("R5 status cleared", rd, 32'h0000_0003);
    chk("R9 irq after clear", 32'(irq), 32'h0);

    // R4 only kept bits latch
    evtPulse(0, 8'hFF);
    busRead(8'h80, 4'h4, rd); chk("R4 kept bits", rd, 32'h0051_0003);

    // R4 status not writable, R5 read without lane 2 keeps status
    evtPulse(0, 8'h10);
    busWrite(8'h80, 32'h00FF_0000, 4'h4);
    busRead(8'h80, 4'h3, rd); chk("R4 status write ignored", rd, 32'h0010_0003);
    busRead(8'h80, 4'h4, rd); chk("R5 no clear without lane2", rd, 32'h0010_0003);

    // R5 event coincident with clearing read
    evtPulse(0, 8'h10);
    @(negedge clk);
    busAddr = 8'h80; busBe = 4'h4; busRdEn = 1'b1; engEvt[7:0] = 8'h01;
    @(negedge clk);
    busRdEn = 1'b0; busBe = '0; engEvt = '0;
    chk("R5 returns prior value", busRdData, 32'h0010_0003);
    busRead(8'h80, 4'h3, rd); chk("R5 coincident event kept", rd, 32'h0001_0003);

    // R9 mask
    chk("R9 irq unmasked", 32'(irq), 32'h1);
    busWrite(8'h80, 32'h0000_0100, 4'h2);
    chk("R9 irq masked", 32'(irq), 32'h0);
    busRead(8'h80, 4'h3, rd); chk("R9 mask readback", rd, 32'h0001_0103);
    busWrite(8'h80, 32'h0000_0000, 4'h2);
    chk("R9 irq unmasked again", 32'(irq), 32'h1);
    busRead(8'h80, 4'h4, rd);
    chk("R9 irq cleared", 32'(irq), 32'h0);

    // R8 engine reset keeps settings
    busWrite(8'h8C, 32'hDEAD_BEEF, 4'hF);
    busWrite(8'h84, 32'h0000_1234, 4'h3);
    busWrite(8'h94, 32'hAAAA_5555, 4'hF);
    busWrite(8'h90, 32'hCAFE_F00D, 4'hF);
    evtPulse(0, 8'h40);
    busWrite(8'h80, 32'h0000_0023, 4'h1);
    chk("R8 engReset high", 32'(engReset), 32'h1);
    chk("R8 irq dropped", 32'(irq), 32'h0);
    evtPulse(0, 8'h51);
    busRead(8'h80, 4'h3, rd); chk("R8 events ignored", rd, 32'h0000_0023);
    busWrite(8'h80, 32'h0000_00A3, 4'h1);
    chk("R7 go with reset set", 32'(startPulse), 32'h0);
    chk("R8 next kept", nextPtr[31:0], 32'hDEAD_BEEF);
    chk("R8 count kept", 32'(pktCount[15:0]), 32'h1234);
    chk("R8 in thr kept", 32'(inThr[15:0]), 32'h5555);
    chk("R8 out thr kept", 32'(outThr[15:0]), 32'hAAAA);
    chk("R8 lookup kept", lookupWord[31:0], 32'hCAFE_F00D);
    busWrite(8'h80, 32'h0000_0083, 4'h1);
    chk("R8 release and start", {30'h0, engReset[0], startPulse[0]}, 32'h1);
    evtPulse(0, 8'h40);
    busRead(8'h80, 4'h4, rd);

    // R2 byte lanes and unmapped words
    busWrite(8'h84, 32'h0000_BB00, 4'h2);
    busRead(8'h84, 4'hF, rd); chk("R2 lane merge", rd, 32'h0000_BB34);
    busRead(8'h88, 4'hF, rd); chk("R2 unmapped read", rd, 32'h0);
    busWrite(8'h88, 32'hFFFF_FFFF, 4'hF);
    busRead(8'h88, 4'hF, rd); chk("R2 unmapped write", rd, 32'h0);
    chk("R2 pio mode", 32'(pioMode), 32'h3);

    // R11 other channel untouched
    busRead(8'hA4, 4'hF, rd); chk("R11 ch1 count", rd, 32'h0);
    busRead(8'hAC, 4'hF, rd); chk("R11 ch1 next", rd, 32'h0);
    busRead(8'hA0, 4'h3, rd); chk("R11 ch1 ctrl", rd, 32'h0000_0100);
    chk("R11 ch1 outputs", {29'h0, irq[1], engReset[1], startPulse[1]}, 32'h0);

    // random phase against the bench model
    mCount[0] = 16'hBB34; mNext[0] = 32'hDEAD_BEEF; mLook[0] = 32'hCAFE_F00D;
    mIn[0] = 16'h5555; mOut[0] = 16'hAAAA; mSt[0] = 8'h0; mCtrl[0] = 16'h0003;
    mCount[1] = '0; mNext[1] = '0; mLook[1] = '0; mIn[1] = '0; mOut[1] = '0;
    mSt[1] = '0; mCtrl[1] = 16'h0100;

    for (int it = 0; it < 400; it++) begin
      int ch, op, word;
      logic [3:0]  be;
      logic [31:0] d, nw;
      logic [7:0]  e;
      ch = int'($urandom % 2);
      op = int'($urandom % 4);
      case ($urandom % 4)
        0: word = 1;
        1: word = 3;
        2: word = 4;
        default: word = 5;
      endcase
      be = 4'($urandom % 15 + 1);
      d  = $urandom;
      e  = 8'($urandom);
      case (op)
        0: begin
          busWrite(regAddr(ch, word), d, be);
          nw = byteMix(modelWord(ch, word), d, be);
          case (word)
            1: mCount[ch] = nw[15:0];
            3: mNext[ch]  = nw;
            4: mLook[ch]  = nw;
            default: begin mIn[ch] = nw[15:0]; mOut[ch] = nw[31:16]; end
          endcase
          chk("R2 random count port", 32'(pktCount[ch*16 +: 16]), 32'(mCount[ch]));
          chk("R2 random thr port", {outThr[ch*16 +: 16], inThr[ch*16 +: 16]},
              {mOut[ch], mIn[ch]});
          chk("R11 random other next", nextPtr[(1-ch)*32 +: 32], mNext[1-ch]);
        end
        1: begin
          busRead(regAddr(ch, word), 4'hF, rd);
          chk("R2 random readback", rd, modelWord(ch, word));
        end
        2: begin
          evtPulse(ch, e);
          mSt[ch] = mSt[ch] | (e & 8'h51);
          chk("R4 random irq", 32'(irq),
              {30'h0, (|mSt[1]) & ~mCtrl[1][8], (|mSt[0]) & ~mCtrl[0][8]});
        end
        default: begin
          busRead(regAddr(ch, 0), 4'h4, rd);
          chk("R5 random status", rd, modelWord(ch, 0));
          mSt[ch] = 8'h0;
        end
      endcase
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule